// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs an 8-bit successive-approximation conversion against an external comparator and a trial DAC. A one-cycle start request from the host begins a conversion. The block then resolves the code one bit at a time, beginning with the most significant bit. For each bit it raises that bit in the trial code and lets the analog side settle for a parameterised number of clocks. It then samples the comparator and either keeps the bit or clears it.

The busy output stays high from the cycle after start until the result is latched. The same signal drives the hold control of the sample-and-hold stage in front of the comparator, so the analog input stays frozen while the bits are resolved. Every conversion takes the same number of cycles. A host can therefore read the result register after that known delay and does not need to watch busy. The previous result stays readable for the whole conversion. A one-cycle done pulse marks the moment the new result replaces it.

Top module: `sar_conv_ctrl`

## Requirements
- R1: When start is high at a clock edge while busy is low, busy is high in the next cycle and trial_code is 8'h80 (only the most significant bit set).
- R2: Bits are resolved from bit 7 down to bit 0. In the last clock of its bit-period, the bit under trial is kept if cmp_hi is 1 (input at or above the trial level) and cleared if cmp_hi is 0. The next lower bit is then set. With an ideal comparator the result equals the held input code, for every input from 0 to 255.
- R3: busy stays high for exactly 8*CLKS_PER_BIT+1 consecutive cycles per conversion: eight bit-periods plus one latch cycle.
- R4: busy serves as the hold control. The result reflects the input captured at the start of the conversion, even if the input moves while busy is high.
- R5: A start request while busy is high, including in the final latch cycle, is ignored. The conversion length and result do not change, and no second conversion follows.
- R6: done is a single-cycle pulse. It is high in the first cycle after busy falls, and result shows the new code in that same cycle.
- R7: result keeps the previous conversion's value until done is asserted.
- R8: After reset, busy, done, result and trial_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_hi | input | 1 | Comparator: 1 when the held input is at or above the trial level |
| trial_code | output | WIDTH | Code driven to the trial DAC |
| busy | output | 1 | Conversion in progress; also the sample-and-hold hold control |
| done | output | 1 | One-cycle pulse when result updates |
| result | output | WIDTH | Last completed conversion code |

## Verification
The checker module tests these properties on every cycle:
- an accepted start raises busy with the trial code at its midscale seed;
- busy never outlasts its fixed length, and each busy period ends after exactly that length;
- done lasts a single cycle and follows the fall of busy;
- result does not change unless done is high.

Only the bench scenarios can show the following:
- The bit decisions are correct. The bench runs an ideal comparator model against all 256 input codes.
- The hold behaviour keeps the result tied to the value captured at start, even when the input is disturbed during conversion.
- Start pulses during a conversion, including one in the latch cycle, neither lengthen the conversion nor queue a second one.

// File: rtl/sar_ctrl_pkg.sv
// Package: shared state encoding for the successive-approximation sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sar_ctrl_pkg;

    // Sequencer phases: waiting, resolving bits, latching the result.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_LATCH = 2'd2
    } sar_state_t;

endpackage

// File: rtl/sar_bit_timer.sv
// Module: sar_bit_timer
// Counts system clocks inside one bit-period and flags its final clock.
// Assumes: CLKS_PER_BIT >= 1; clear has priority and restarts the period.
module sar_bit_timer #(
    parameter int CLKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic bit_end
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Purpose: advance the in-period clock counter, wrapping at the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Purpose: mark the clock on which the comparator decision is taken.
    always_comb begin
        bit_end = run && (cnt == LAST);
    end

endmodule

// File: rtl/sar_approx_reg.sv
// Module: sar_approx_reg
// Holds the trial code and a one-hot pointer to the bit under trial.
// Assumes: WIDTH >= 2; load seeds midscale; step applies one comparator decision.
module sar_approx_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] code,
    output logic             last_bit
);
    localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] probe;

    // Purpose: seed the trial, then keep or drop the probed bit and move down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= '0;
            probe <= '0;
        end else if (load) begin
            code  <= SEED;
            probe <= SEED;
        end else if (step) begin
            code  <= (cmp_hi ? code : (code & ~probe)) | (probe >> 1);
            probe <= probe >> 1;
        end
    end

    // Purpose: report that the least significant bit is the one under trial.
    always_comb begin
        last_bit = probe[0];
    end

endmodule

// File: rtl/sar_result_reg.sv
// Module: sar_result_reg
// Latches a finished code for the host and pulses done for one clock.
// Assumes: capture is a single-cycle strobe.
module sar_result_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] code,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    // Purpose: keep the previous result until a capture replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (capture) begin
            result <= code;
        end
    end

    // Purpose: one-clock completion pulse aligned with the result update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= capture;
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: sar_conv_ctrl (top)
// Sequences an MSB-first successive-approximation conversion with a fixed
// length of WIDTH bit-periods plus one latch cycle; busy doubles as hold.
// Assumes: cmp_hi is valid by the last clock of each bit-period.
module sar_conv_ctrl #(
    parameter int WIDTH        = 8,
    parameter int CLKS_PER_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_code,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    import sar_ctrl_pkg::*;

    sar_state_t state;
    logic       accept;
    logic       bit_end;
    logic       last_bit;
    logic       in_conv;

    // Purpose: decode request acceptance and the resolving phase.
    always_comb begin
        accept  = (state == ST_IDLE) && start;
        in_conv = (state == ST_CONV);
        busy    = (state != ST_IDLE);
    end

    // Purpose: phase sequencing; requests outside idle are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_CONV;
                ST_CONV:  if (bit_end && last_bit) state <= ST_LATCH;
                ST_LATCH: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    sar_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (in_conv),
        .bit_end (bit_end)
    );

    sar_approx_reg #(.WIDTH(WIDTH)) u_approx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (bit_end),
        .cmp_hi   (cmp_hi),
        .code     (trial_code),
        .last_bit (last_bit)
    );

    sar_result_reg #(.WIDTH(WIDTH)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state == ST_LATCH),
        .code    (trial_code),
        .result  (result),
        .done    (done)
    );

endmodule

// File: rtl/sar_conv_ctrl_checker.sv
// Module: sar_conv_ctrl_checker
// Cycle-level properties of the sequencer's ports, bound to every instance.
// Assumes: synchronous active-low reset; busy-length window kept by a counter.
module sar_conv_ctrl_checker #(
    parameter int WIDTH        = 8,
    parameter int CLKS_PER_BIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] trial_code,
    input logic [WIDTH-1:0] result
);
    localparam int BUSY_LEN = WIDTH * CLKS_PER_BIT + 1;
    localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

    int busy_cnt;

    // Purpose: count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    a_r1_start_seeds_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && trial_code == SEED));

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < BUSY_LEN));

    a_r3_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == BUSY_LEN));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_checker #(
    .WIDTH        (WIDTH),
    .CLKS_PER_BIT (CLKS_PER_BIT)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .trial_code (trial_code),
    .result     (result)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int K          = 4;
    localparam int N_BUSY     = 8 * K + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] vin = 8'd0;
    logic [7:0] held_v = 8'd0;
    logic       cmp_hi;
    logic [7:0] trial_code;
    logic       busy, done;
    logic [7:0] result;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sample-and-hold model: tracks vin only while busy (hold) is low.
    always @(posedge clk) if (!busy) held_v <= vin;
    assign cmp_hi = (held_v >= trial_code);

    sar_conv_ctrl #(.WIDTH(8), .CLKS_PER_BIT(K)) u_sar_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
        .trial_code(trial_code), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    // One conversion of v; disturb moves vin during busy, poke raises start mid-run.
    task automatic convert(input logic [7:0] v, input bit disturb, input bit poke);
        logic [7:0] prev;
        int n;
        prev = result;
        vin = v;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R1 busy", busy, 1);
        chk(trial_code === 8'h80, "R1 seed", trial_code, 128);
        n = 0;
        while (busy === 1'b1 && n < 100) begin
            n++;
            chk(result === prev && done === 1'b0, "R7 held", result, prev);
            if (disturb) vin = ~v;
            start = poke && (n == 3 || n == N_BUSY);
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == N_BUSY, poke ? "R5 length" : "R3 length", n, N_BUSY);
        chk(done === 1'b1, "R6 done", done, 1);
        chk(result === v, disturb ? "R4 hold" : (poke ? "R5 result" : "R2 code"), result, v);
        @(negedge clk);
        chk(done === 1'b0, "R6 single", done, 0);
        chk(busy === 1'b0, poke ? "R5 no requeue" : "R6 idle", busy, 0);
        vin = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(busy === 1'b0, "R8 busy", busy, 0);
        chk(done === 1'b0, "R8 done", done, 0);
        chk(result === 8'd0, "R8 result", result, 0);
        chk(trial_code === 8'd0, "R8 trial", trial_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 full sweep of input codes
        for (int v = 0; v < 256; v++) convert(8'(v), 1'b0, 1'b0);
        // R4 input disturbed during hold
        convert(8'h5A, 1'b1, 1'b0);
        convert(8'hFF, 1'b1, 1'b0);
        convert(8'h00, 1'b1, 1'b0);
        // R5 start requests while busy, including in the latch cycle
        convert(8'hC3, 1'b0, 1'b1);
        convert(8'h01, 1'b0, 1'b1);
        summary();
    end
endmodule